// File: doc/BRIEF.md
# Time-Shared FIR Sequencer with One Multiply-Add Unit

This block produces one output of a 63-tap direct-form FIR filter for each accepted input sample. It uses a single external pipelined multiply-add unit for every tap instead of one multiplier per tap. It keeps a delay line of 32-bit words and a computed table of constant coefficients. For each tap it presents three operands to the unit: a is the delay-line word, b is the coefficient and c is the running accumulator. It waits out the unit's fixed latency and then loads the returned a*b+c back into the accumulator. That value becomes the addend of the next tap, so no chaining between units is needed.

The controller has two named states. `ST_IDLE` waits for a sample. The transition *accept* (input valid while in `ST_IDLE`) does four things: it shifts the delay line, puts the new word at position 0, clears the accumulator and resets the tap index and phase counter. `ST_MAC` then walks the taps. A phase counter counts up from 0 to the latency value. On the *capture* step (phase equal to the latency) the result is loaded and the phase returns to 0. The transition *finish* (capture on the last tap) returns to `ST_IDLE` and publishes the result. Multiply-add latency and tap count are parameters. Each tap always takes latency + 1 cycles, which is 6 cycles with the default latency of 5. One output takes 378 cycles, well inside a sample period of about 2048 cycles at 100 MHz.

Top module: `tsmac_fir_seq`

## Requirements
- R1: After reset, `out_valid` is low, `out_sample` is zero, every delay-line word is zero and the block is idle in `ST_IDLE`.
- R2: An accepted sample enters delay position 0 and older words move up one position. The result equals the chain c(k+1) = a(k)*b(k) + c(k) for k = 0..TAPS-1, starting from c(0) = 0, where a(k) is the sample accepted k samples earlier (zero if none).
- R3: The phase counter never exceeds LATENCY. Each tap occupies exactly LATENCY+1 cycles, and the unit's result is captured when the phase equals LATENCY.
- R4: Within one tap the operands are a = delay word at the tap index, b = that tap's coefficient and c = the accumulator. All three stay stable for the whole tap window.
- R5: `out_valid` rises exactly TAPS*(LATENCY+1) clock edges after the accepting edge (378 with the defaults). At that point `out_sample` carries the final captured value and the block is back in `ST_IDLE`.
- R6: `out_valid` is a one-cycle pulse, and `out_sample` holds its value until the next result.
- R7: An `in_valid` that arrives while the block is in `ST_MAC` is ignored. The delay line does not shift, the computation is not restarted and the pending result is unchanged.
- R8: The coefficient of tap k is the 32-bit value 2*k+1.
- R9: On accept the accumulator is cleared, so `mac_c` is zero throughout tap 0 of every computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sample | input | 32 | New input word |
| in_valid | input | 1 | Input word present (accepted only when idle) |
| out_sample | output | 32 | Filter result, held between results |
| out_valid | output | 1 | One-cycle pulse when a new result is available |
| mac_a | output | 32 | Multiply-add operand a (delay-line word) |
| mac_b | output | 32 | Multiply-add operand b (coefficient) |
| mac_c | output | 32 | Multiply-add addend c (accumulator) |
| mac_result | input | 32 | a*b+c returned LATENCY cycles after the operands |

## Verification
The bench attaches an integer multiply-add pipeline of the stated latency. It first sends an impulse, which exposes the tap-0 coefficient and the total cycle count. It then sends a series of seeded random words, which checks delay-line ordering against the chain of partial sums over the whole history. All-ones words make the products and the accumulator wrap, which shows that every capture feeds the next addend. Sample strobes injected in the middle of a computation must leave both the pending result and the following one unchanged, which separates an ignored strobe from one that shifts the delay line or restarts the count.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MAC  = 1'b1
    } seq_state_t;

    // Coefficient of tap k: a fixed ramp of odd values.
    function automatic logic [31:0] coef_value(input int unsigned k);
        return 32'(2 * k + 1);
    endfunction

endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 63,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] shift_in,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] words_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[i] <= '0;
            end else if (shift_en) begin
                if (i == 0) begin
                    words_q[i] <= shift_in;
                end else begin
                    words_q[i] <= words_q[i-1];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (rd_idx == IDX_W'(j)) begin
                rd_data = words_q[j];
            end
        end
    end

endmodule

// File: rtl/fir_coef_table.sv
module fir_coef_table #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 63,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] coef
);
    import fir_seq_pkg::*;

    always_comb begin
        coef = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (idx == IDX_W'(j)) begin
                coef = WIDTH'(coef_value(j));
            end
        end
    end

endmodule

// File: rtl/fir_tap_sequencer.sv
module fir_tap_sequencer #(
    parameter int WIDTH   = 32,
    parameter int TAPS    = 63,
    parameter int LATENCY = 5,
    localparam int IDX_W  = $clog2(TAPS),
    localparam int PH_W   = $clog2(LATENCY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] mac_result,
    output logic             accept,
    output logic             busy,
    output logic [IDX_W-1:0] tap_idx,
    output logic [PH_W-1:0]  phase,
    output logic [WIDTH-1:0] acc,
    output logic [WIDTH-1:0] out_sample,
    output logic             out_valid
);
    import fir_seq_pkg::*;

    localparam logic [IDX_W-1:0] TAP_LAST = IDX_W'(TAPS - 1);
    localparam logic [PH_W-1:0]  PH_CAP   = PH_W'(LATENCY);

    seq_state_t state_q, state_nx;

    logic capture;
    assign capture = (state_q == ST_MAC) && (phase == PH_CAP);
    assign accept  = (state_q == ST_IDLE) && start;
    assign busy    = (state_q == ST_MAC);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_nx = ST_MAC;
            ST_MAC:  if (capture && tap_idx == TAP_LAST) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_idx    <= '0;
            phase      <= '0;
            acc        <= '0;
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        acc     <= '0;
                        tap_idx <= '0;
                        phase   <= '0;
                    end
                end
                ST_MAC: begin
                    if (capture) begin
                        acc   <= mac_result;
                        phase <= '0;
                        if (tap_idx == TAP_LAST) begin
                            out_sample <= mac_result;
                            out_valid  <= 1'b1;
                        end else begin
                            tap_idx <= tap_idx + IDX_W'(1);
                        end
                    end else begin
                        phase <= phase + PH_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/tsmac_fir_seq.sv
module tsmac_fir_seq #(
    parameter int WIDTH   = 32,
    parameter int TAPS    = 63,
    parameter int LATENCY = 5,
    localparam int IDX_W  = $clog2(TAPS),
    localparam int PH_W   = $clog2(LATENCY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_sample,
    input  logic             in_valid,
    output logic [WIDTH-1:0] out_sample,
    output logic             out_valid,
    output logic [WIDTH-1:0] mac_a,
    output logic [WIDTH-1:0] mac_b,
    output logic [WIDTH-1:0] mac_c,
    input  logic [WIDTH-1:0] mac_result
);

    logic             accept;
    logic             busy;
    logic [IDX_W-1:0] tap_idx;
    logic [PH_W-1:0]  phase;
    logic [WIDTH-1:0] acc;

    fir_tap_sequencer #(
        .WIDTH(WIDTH), .TAPS(TAPS), .LATENCY(LATENCY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (in_valid),
        .mac_result (mac_result),
        .accept     (accept),
        .busy       (busy),
        .tap_idx    (tap_idx),
        .phase      (phase),
        .acc        (acc),
        .out_sample (out_sample),
        .out_valid  (out_valid)
    );

    fir_delay_line #(
        .WIDTH(WIDTH), .DEPTH(TAPS)
    ) u_dline (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .shift_in (in_sample),
        .rd_idx   (tap_idx),
        .rd_data  (mac_a)
    );

    fir_coef_table #(
        .WIDTH(WIDTH), .DEPTH(TAPS)
    ) u_coef (
        .idx  (tap_idx),
        .coef (mac_b)
    );

    assign mac_c = acc;

endmodule

// File: rtl/tsmac_fir_seq_chk.sv
module tsmac_fir_seq_chk #(
    parameter int WIDTH   = 32,
    parameter int TAPS    = 63,
    parameter int LATENCY = 5,
    localparam int IDX_W  = $clog2(TAPS),
    localparam int PH_W   = $clog2(LATENCY + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             busy,
    input logic [IDX_W-1:0] tap_idx,
    input logic [PH_W-1:0]  phase,
    input logic [WIDTH-1:0] mac_a,
    input logic [WIDTH-1:0] mac_b,
    input logic [WIDTH-1:0] mac_c
);

    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase <= PH_W'(LATENCY)));

    p_operand_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != '0) |-> ($stable(mac_a) && $stable(mac_b) && $stable(mac_c)));

    p_done_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (tap_idx == IDX_W'(TAPS - 1)));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid && !(phase == PH_W'(LATENCY) && tap_idx == IDX_W'(TAPS - 1)))
        |=> busy);

    p_acc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid) |=> (mac_c == '0 && tap_idx == '0));

endmodule

bind tsmac_fir_seq tsmac_fir_seq_chk #(
    .WIDTH(WIDTH), .TAPS(TAPS), .LATENCY(LATENCY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .busy      (busy),
    .tap_idx   (tap_idx),
    .phase     (phase),
    .mac_a     (mac_a),
    .mac_b     (mac_b),
    .mac_c     (mac_c)
);

// File: tb/test_tsmac_fir_seq.sv
module test_tsmac_fir_seq;

    localparam int W    = 32;
    localparam int TAPS = 63;
    localparam int LAT  = 5;
    localparam int RUN_CYCLES = TAPS * (LAT + 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic         in_valid = 1'b0;
    logic [W-1:0] out_sample;
    logic         out_valid;
    logic [W-1:0] mac_a, mac_b, mac_c, mac_result;

    int n_cmp = 0;
    int n_bad = 0;

    logic [W-1:0] hist [TAPS];
    logic [W-1:0] pipe [LAT];

    always #4 clk = ~clk;

    tsmac_fir_seq #(.WIDTH(W), .TAPS(TAPS), .LATENCY(LAT)) i_tsmac_fir_seq (
        .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .in_valid(in_valid),
        .out_sample(out_sample), .out_valid(out_valid),
        .mac_a(mac_a), .mac_b(mac_b), .mac_c(mac_c), .mac_result(mac_result)
    );

    // Integer multiply-add model with LAT register stages.
    always @(posedge clk) begin
        pipe[0] <= mac_a * mac_b + mac_c;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign mac_result = pipe[LAT-1];

    function automatic logic [W-1:0] coef_of(int k);
        return W'(2 * k + 1);
    endfunction

    function automatic logic [W-1:0] expected_out();
        logic [W-1:0] c = '0;
        for (int k = 0; k < TAPS; k++) c = hist[k] * coef_of(k) + c;
        return c;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Send one sample while idle; optionally inject a strobe mid-computation.
    task automatic send(input logic [W-1:0] x, input bit inject);
        int cnt;
        logic [W-1:0] exp;
        logic [W-1:0] held;
        @(negedge clk);
        in_sample = x;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        exp = expected_out();
        // tap 0 operands visible right after accept (R4, R9)
        check("R9 addend cleared", mac_c, '0);
        check("R4 operand a", mac_a, x);
        check("R8 coef tap0", mac_b, 32'd1);
        cnt = 0;
        while (!out_valid && cnt < 4 * RUN_CYCLES) begin
            if (inject && cnt == 100) begin
                in_sample = ~x;
                in_valid  = 1'b1;
            end else begin
                in_valid  = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        in_valid = 1'b0;
        check("R5 cycles to result", W'(cnt), W'(RUN_CYCLES));
        check(inject ? "R7 busy strobe ignored" : "R2 filter output", out_sample, exp);
        held = out_sample;
        @(negedge clk);
        check("R6 single pulse", W'(out_valid), 32'd0);
        repeat (3) @(negedge clk);
        check("R6 output held", out_sample, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int k = 0; k < TAPS; k++) hist[k] = '0;
        repeat (3) @(negedge clk);
        check("R1 out_valid reset", W'(out_valid), 32'd0);
        check("R1 out_sample reset", out_sample, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", W'(out_valid), 32'd0);

        // impulse: output is coefficient 0 (R2, R8)
        send(32'd1, 1'b0);
        // random history (R2, R3)
        for (int i = 0; i < 12; i++) send($urandom, 1'b0);
        // strobes during computation ignored (R7)
        send($urandom, 1'b1);
        send($urandom, 1'b1);
        send($urandom, 1'b0);
        // wrap-around words (R2)
        for (int i = 0; i < 4; i++) send(32'hFFFF_FFFF, 1'b0);
        send(32'h8000_0000, 1'b1);

        finish_run();
    end

endmodule